// File: doc/BRIEF.md
# T1 Extended Superframe Transmit Framer

This block builds the 24-frame extended superframe on a serial T1/J1 transmit stream. One bit enters and one bit leaves on every clock. A frame is 193 bits long, and its first bit is the framing bit. The block keeps its own frame position from reset. At each framing bit it fills in one of three things: an alignment-sequence bit, a bit of the CRC-6 computed over the previous superframe, or a data-link bit. All other bits pass through from `din`, with a one-cycle register delay.

The data-link bit is taken from the highest-priority source that is active. The sources are yellow alarm, bit-oriented code, performance report, HDLC and idle pattern. The yellow and idle patterns are 16 bits long and change with the T1/J1 mode. The content of the message sources is produced outside the block. Each message source arrives as a bit plus a valid flag. The outputs `dl_slot` and `dl_src` tell the sources when a bit is taken and which source supplied it.

Diagnostic controls cover four cases. Strobes invert one CRC pattern or one alignment bit. A bypass hands the CRC positions or the data-link positions back to the input stream. A framing disable makes the block transparent. A mimic option copies each framing bit into the bit that follows it.

Top module: `esf_framer_tx`

## Requirements
- R1: While `rst_n` is low, `tx_data`, `tx_fpos` and `tx_sf_start` are 0. The first bit taken after reset is the framing bit of frame 1. Each output bit appears one clock after its input bit.
- R2: With `fdis`=0, the framing bits of frames 4, 8, 12, 16, 20 and 24 carry 0,0,1,0,1,1 in that order.
- R3: The CRC-6 uses x^6+x+1 and is cleared at each superframe start. It runs over all 4632 transmitted bits, MSB of the register first, and every framing bit is counted as 1. It is latched at the end of the superframe. With `fdis`=0 and `crc_byp`=0, the latched value is sent MSB first in the framing bits of frames 2, 6, 10, 14, 18 and 22. During the first superframe after reset the value sent is 000000.
- R4: With `crc_byp`=1, the six CRC positions carry the input bit unchanged.
- R5: With `fdis`=1, every output bit equals its input bit, and `dl_slot` stays 0.
- R6: A `crc_inv_req` pulse inverts all six bits of the next CRC pattern whose first bit is sent after the pulse.
- R7: A `fs_inv_req` pulse inverts only the next alignment bit sent after the pulse.
- R8: The data-link bits sit in the odd-numbered frames. The source is chosen by priority, highest first: yellow, bit-oriented code, performance report, HDLC, idle. `dl_src` encodes the choice as 1, 2, 3, 4 and 5 respectively, and 0 when no source is chosen.
- R9: With `dl_byp`=1, only yellow can be inserted. A data-link position with no yellow carries the input bit, and `dl_src` is 0.
- R10: The yellow pattern is FF00 in T1 mode and FFFF in J1 mode (`j1_mode`=1). The idle pattern is FFFF in T1 mode and FF7E in J1 mode. A pattern is sent MSB first and moves one bit on each data-link slot that uses it. It wraps after 16 bits, and it starts again at its MSB whenever the chosen source differs from the source chosen at the previous slot.
- R11: Yellow is requested by `yel_force`, or by `red_alarm` when `auto_yel_en`=1.
- R12: With `fdis`=0 and `mimic_en`=1, the bit that follows each framing bit repeats that framing bit as it was transmitted.
- R13: `tx_fpos` is high with every output framing bit. `tx_sf_start` is high with the framing bit of frame 1. `dl_slot` is high exactly in the input cycle of a data-link framing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial input stream, 193 bits per frame |
| j1_mode | input | 1 | 1 selects the J1 yellow and idle patterns |
| fdis | input | 1 | Framing disable: the block becomes transparent |
| crc_byp | input | 1 | CRC positions carry input bits |
| dl_byp | input | 1 | Data-link positions carry input bits unless yellow is sent |
| mimic_en | input | 1 | Copy each framing bit into the following bit |
| crc_inv_req | input | 1 | Pulse: invert the next CRC pattern |
| fs_inv_req | input | 1 | Pulse: invert the next alignment bit |
| yel_force | input | 1 | Manual yellow alarm request |
| auto_yel_en | input | 1 | Send yellow while red alarm is present |
| red_alarm | input | 1 | Red alarm declared on the receive side |
| boc_valid | input | 1 | Bit-oriented code bit is valid |
| boc_bit | input | 1 | Bit-oriented code bit |
| prm_valid | input | 1 | Performance report bit is valid |
| prm_bit | input | 1 | Performance report bit |
| hdlc_valid | input | 1 | HDLC bit is valid |
| hdlc_bit | input | 1 | HDLC bit |
| tx_data | output | 1 | Serial framed output |
| tx_fpos | output | 1 | `tx_data` is a framing bit |
| tx_sf_start | output | 1 | `tx_data` is the framing bit of frame 1 |
| dl_slot | output | 1 | This input cycle is a data-link slot |
| dl_src | output | 3 | Data-link source used in this cycle |

## Verification
The stream is driven with pseudo-random payload over whole superframes. A CRC error in any frame, a wrong phase of the CRC latch, or a misplaced framing bit therefore shows up in the six CRC bits that follow. The source valid flags are randomized on every data-link slot, and yellow is raised both manually and through red alarm, in each mode. These runs separate the priority order from the pattern index behaviour, including the restart when the source changes. Further runs with each bypass, with mimic and with framing disabled check which positions fall back to the input. The inversion strobes, placed just before a target, show that exactly one pattern or one bit is affected.

// File: rtl/esf_tx_pkg.sv
package esf_tx_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_YEL  = 3'd1,
    SRC_BOC  = 3'd2,
    SRC_PRM  = 3'd3,
    SRC_HDLC = 3'd4,
    SRC_IDLE = 3'd5
  } dl_src_e;

  localparam logic [15:0] YEL_PAT_T1  = 16'hFF00;
  localparam logic [15:0] YEL_PAT_J1  = 16'hFFFF;
  localparam logic [15:0] IDLE_PAT_T1 = 16'hFFFF;
  localparam logic [15:0] IDLE_PAT_J1 = 16'hFF7E;
  localparam logic [5:0]  ALIGN_SEQ   = 6'b001011;

  // one serial step of the x^6 + x + 1 divider
  function automatic logic [5:0] crc6_step(input logic [5:0] c, input logic d);
    logic fb;
    fb = c[5] ^ d;
    return {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
  endfunction

  // MSB-first fetch from a 16-bit pattern
  function automatic logic pattern_bit(input logic [15:0] p, input logic [3:0] i);
    return p[4'd15 - i];
  endfunction

  // k-th alignment bit, k = 0 for frame 4
  function automatic logic align_bit(input logic [2:0] k);
    return ALIGN_SEQ[3'd5 - k];
  endfunction

  // k-th transmitted CRC bit, MSB first
  function automatic logic crc_pick(input logic [5:0] c, input logic [2:0] k);
    return c[3'd5 - k];
  endfunction

endpackage

// File: rtl/esf_tx_position.sv
module esf_tx_position #(
  parameter int FRAME_BITS = 193,
  parameter int SF_FRAMES  = 24,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(SF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [BIT_W-1:0] bit_idx,
  output logic [FRM_W-1:0] frm_idx,
  output logic             sf_end
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(SF_FRAMES - 1);

  logic frame_end;
  assign frame_end = (bit_idx == BIT_LAST);
  assign sf_end    = frame_end && (frm_idx == FRM_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= '0;
      frm_idx <= '0;
    end else begin
      bit_idx <= frame_end ? '0 : bit_idx + 1'b1;
      if (frame_end) frm_idx <= (frm_idx == FRM_LAST) ? '0 : frm_idx + 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_idx == '0)) else $error("frame wrap"); // R13
  AST_SF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> (frm_idx == '0)) else $error("superframe wrap"); // R13
endmodule

// File: rtl/esf_tx_crc6.sv
module esf_tx_crc6 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feed,
  input  logic       sf_end,
  output logic [5:0] crc_hold
);
  import esf_tx_pkg::*;

  logic [5:0] crc_acc;
  logic [5:0] crc_next;

  assign crc_next = crc6_step(crc_acc, feed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_acc  <= '0;
      crc_hold <= '0;
    end else if (sf_end) begin
      crc_acc  <= '0;
      crc_hold <= crc_next;
    end else begin
      crc_acc  <= crc_next;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_end |=> $stable(crc_hold)) else $error("crc hold moved"); // R3
  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> (crc_acc == 6'd0)) else $error("crc not restarted"); // R3
endmodule

// File: rtl/esf_tx_dl_mux.sv
module esf_tx_dl_mux (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot,
  input  logic                 j1_mode,
  input  logic                 yel_req,
  input  logic                 dl_byp,
  input  logic                 boc_valid,
  input  logic                 boc_bit,
  input  logic                 prm_valid,
  input  logic                 prm_bit,
  input  logic                 hdlc_valid,
  input  logic                 hdlc_bit,
  output esf_tx_pkg::dl_src_e  src,
  output logic                 dl_bit
);
  import esf_tx_pkg::*;

  logic [4:0] grant;     // yel, boc, prm, hdlc, idle
  logic [3:0] pat_idx;
  dl_src_e    prev_src;
  logic       is_pat;
  logic [3:0] use_idx;
  logic [15:0] pat;

  always_comb begin
    grant = '0;
    if (slot) begin
      if (yel_req)         grant[0] = 1'b1;
      else if (!dl_byp) begin
        if (boc_valid)       grant[1] = 1'b1;
        else if (prm_valid)  grant[2] = 1'b1;
        else if (hdlc_valid) grant[3] = 1'b1;
        else                 grant[4] = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (1'b1)
      grant[0]: src = SRC_YEL;
      grant[1]: src = SRC_BOC;
      grant[2]: src = SRC_PRM;
      grant[3]: src = SRC_HDLC;
      grant[4]: src = SRC_IDLE;
      default:  src = SRC_NONE;
    endcase
  end

  assign is_pat  = grant[0] | grant[4];
  assign use_idx = (src == prev_src) ? pat_idx : 4'd0;
  assign pat     = grant[0] ? (j1_mode ? YEL_PAT_J1 : YEL_PAT_T1)
                            : (j1_mode ? IDLE_PAT_J1 : IDLE_PAT_T1);

  always_comb begin
    dl_bit = 1'b0;
    if (is_pat)        dl_bit = pattern_bit(pat, use_idx);
    else if (grant[1]) dl_bit = boc_bit;
    else if (grant[2]) dl_bit = prm_bit;
    else if (grant[3]) dl_bit = hdlc_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_idx  <= '0;
      prev_src <= SRC_NONE;
    end else if (slot) begin
      prev_src <= src;
      pat_idx  <= is_pat ? use_idx + 4'd1 : 4'd0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("multiple grants"); // R8
  AST_YEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && yel_req) |-> (src == SRC_YEL)) else $error("yellow lost"); // R8
  AST_NO_SLOT_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |-> (src == SRC_NONE)) else $error("source outside slot"); // R13
  AST_PAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !is_pat) |=> (pat_idx == 4'd0)) else $error("pattern index kept"); // R10
endmodule

// File: rtl/esf_framer_tx.sv
module esf_framer_tx #(
  parameter int FRAME_BITS = 193,
  parameter int SF_FRAMES  = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       j1_mode,
  input  logic       fdis,
  input  logic       crc_byp,
  input  logic       dl_byp,
  input  logic       mimic_en,
  input  logic       crc_inv_req,
  input  logic       fs_inv_req,
  input  logic       yel_force,
  input  logic       auto_yel_en,
  input  logic       red_alarm,
  input  logic       boc_valid,
  input  logic       boc_bit,
  input  logic       prm_valid,
  input  logic       prm_bit,
  input  logic       hdlc_valid,
  input  logic       hdlc_bit,
  output logic       tx_data,
  output logic       tx_fpos,
  output logic       tx_sf_start,
  output logic       dl_slot,
  output logic [2:0] dl_src
);
  import esf_tx_pkg::*;

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int FRM_W = $clog2(SF_FRAMES);

  logic [BIT_W-1:0] bit_idx;
  logic [FRM_W-1:0] frm_idx;
  logic             sf_end;

  esf_tx_position #(.FRAME_BITS(FRAME_BITS), .SF_FRAMES(SF_FRAMES)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .frm_idx(frm_idx), .sf_end(sf_end)
  );

  // position events, named for the checks
  logic       f_slot, is_dl, is_crc, is_aln;
  logic [2:0] grp;
  logic       crc_slot, aln_slot, mimic_slot, crc_first;
  logic       yel_req;

  assign f_slot     = (bit_idx == '0);
  assign is_dl      = ~frm_idx[0];
  assign is_crc     = (frm_idx[1:0] == 2'b01);
  assign is_aln     = (frm_idx[1:0] == 2'b11);
  assign grp        = 3'(frm_idx >> 2);
  assign dl_slot    = f_slot & is_dl & ~fdis;
  assign crc_slot   = f_slot & is_crc & ~fdis & ~crc_byp;
  assign aln_slot   = f_slot & is_aln & ~fdis;
  assign crc_first  = crc_slot & (grp == 3'd0);
  assign mimic_slot = (bit_idx == BIT_W'(1)) & mimic_en & ~fdis;
  assign yel_req    = yel_force | (auto_yel_en & red_alarm);

  // data-link source selection
  dl_src_e dl_src_e_w;
  logic    dl_bit;

  esf_tx_dl_mux u_dl (
    .clk(clk), .rst_n(rst_n), .slot(dl_slot), .j1_mode(j1_mode), .yel_req(yel_req),
    .dl_byp(dl_byp), .boc_valid(boc_valid), .boc_bit(boc_bit),
    .prm_valid(prm_valid), .prm_bit(prm_bit), .hdlc_valid(hdlc_valid),
    .hdlc_bit(hdlc_bit), .src(dl_src_e_w), .dl_bit(dl_bit)
  );
  assign dl_src = dl_src_e_w;

  // error injection
  logic pend_crc, act_crc, pend_fs, inv_crc_now;
  assign inv_crc_now = (grp == 3'd0) ? pend_crc : act_crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_crc <= 1'b0;
      act_crc  <= 1'b0;
      pend_fs  <= 1'b0;
    end else begin
      pend_crc <= (pend_crc & ~crc_first) | crc_inv_req;
      pend_fs  <= (pend_fs & ~aln_slot) | fs_inv_req;
      if (crc_first) act_crc <= pend_crc;
    end
  end

  // CRC over the transmitted stream
  logic [5:0] crc_hold;
  logic       nxt_bit, last_f;

  esf_tx_crc6 u_crc (
    .clk(clk), .rst_n(rst_n), .feed(f_slot | nxt_bit), .sf_end(sf_end), .crc_hold(crc_hold)
  );

  always_comb begin
    nxt_bit = din;
    if (!fdis) begin
      if (f_slot) begin
        if (is_dl) begin
          if (dl_src_e_w != SRC_NONE) nxt_bit = dl_bit;
        end else if (is_crc) begin
          if (!crc_byp) nxt_bit = crc_pick(crc_hold, grp) ^ inv_crc_now;
        end else begin
          nxt_bit = align_bit(grp) ^ pend_fs;
        end
      end else if (mimic_slot) begin
        nxt_bit = last_f;
      end
    end
  end

  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data     <= 1'b0;
      tx_fpos     <= 1'b0;
      tx_sf_start <= 1'b0;
      last_f      <= 1'b0;
      live        <= 1'b0;
    end else begin
      tx_data     <= nxt_bit;
      tx_fpos     <= f_slot;
      tx_sf_start <= f_slot && (frm_idx == '0);
      live        <= 1'b1;
      if (f_slot) last_f <= nxt_bit;
    end
  end

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(live && fdis) |-> (tx_data == $past(din))) else $error("not transparent"); // R5
  AST_MIMIC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mimic_en && !fdis && tx_fpos) |-> (tx_data == $past(tx_data))) else $error("mimic"); // R12
  AST_SF_IS_F: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sf_start |-> tx_fpos) else $error("sf start off F"); // R13
  AST_FS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (aln_slot && !fs_inv_req) |=> !pend_fs) else $error("fs invert kept"); // R7
endmodule

// File: tb/esf_framer_tx_test.sv
module esf_framer_tx_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, din, j1_mode, fdis, crc_byp, dl_byp, mimic_en, crc_inv_req, fs_inv_req;
  logic yel_force, auto_yel_en, red_alarm, boc_valid, boc_bit, prm_valid, prm_bit;
  logic hdlc_valid, hdlc_bit;
  logic tx_data, tx_fpos, tx_sf_start, dl_slot;
  logic [2:0] dl_src;

  esf_framer_tx uut (
    .clk(clk), .rst_n(rst_n), .din(din), .j1_mode(j1_mode), .fdis(fdis), .crc_byp(crc_byp),
    .dl_byp(dl_byp), .mimic_en(mimic_en), .crc_inv_req(crc_inv_req), .fs_inv_req(fs_inv_req),
    .yel_force(yel_force), .auto_yel_en(auto_yel_en), .red_alarm(red_alarm),
    .boc_valid(boc_valid), .boc_bit(boc_bit), .prm_valid(prm_valid), .prm_bit(prm_bit),
    .hdlc_valid(hdlc_valid), .hdlc_bit(hdlc_bit), .tx_data(tx_data), .tx_fpos(tx_fpos),
    .tx_sf_start(tx_sf_start), .dl_slot(dl_slot), .dl_src(dl_src)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench reference state
  int         m_bit, m_frm, m_pi, m_prev;
  logic [5:0] m_crc, m_hold;
  logic       m_pcrc, m_acrc, m_pfs, m_lastf;
  logic [15:0] lfsr = 16'hACE1;
  bit          rnd_src = 1'b0;
  bit          have_exp = 1'b0;
  logic        e_data, e_fpos, e_sfs;
  string       e_req;

  function automatic logic [5:0] crc_shift(input logic [5:0] c, input logic d);
    logic [5:0] n;
    logic t;
    t = d ^ c[5];
    n[5] = c[4]; n[4] = c[3]; n[3] = c[2]; n[2] = c[1];
    n[1] = c[0] ^ t; n[0] = t;
    return n;
  endfunction

  function automatic logic pat16(input logic [15:0] p, input int i);
    return (p >> (15 - i)) & 16'h1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (frame %0d bit %0d)", req, act, exp, m_frm, m_bit);
    end
  endtask

  task automatic model_reset();
    m_bit = 0; m_frm = 0; m_pi = 0; m_prev = 0;
    m_crc = 0; m_hold = 0; m_pcrc = 0; m_acrc = 0; m_pfs = 0; m_lastf = 0;
  endtask

  // compute expectation for the bit just driven, then advance the model
  task automatic model_step();
    logic o;
    logic fs;
    int   src, k;
    logic [15:0] p;
    fs = (m_bit == 0);
    o = din; e_req = "R13"; src = 0;
    k = m_frm / 4;
    if (fdis) begin
      e_req = "R5";
    end else if (fs) begin
      if (m_frm % 2 == 0) begin
        if (yel_force || (auto_yel_en && red_alarm)) src = 1;
        else if (dl_byp) src = 0;
        else if (boc_valid) src = 2;
        else if (prm_valid) src = 3;
        else if (hdlc_valid) src = 4;
        else src = 5;
        e_req = dl_byp ? "R9" : "R8";
        if (src == 1 || src == 5) begin
          if (src != m_prev) m_pi = 0;
          if (src == 1) p = j1_mode ? 16'hFFFF : 16'hFF00;
          else          p = j1_mode ? 16'hFF7E : 16'hFFFF;
          o = pat16(p, m_pi);
          m_pi = (m_pi + 1) % 16;
          e_req = "R10";
        end else begin
          m_pi = 0;
          if (src == 2) o = boc_bit;
          else if (src == 3) o = prm_bit;
          else if (src == 4) o = hdlc_bit;
        end
        m_prev = src;
        #1;
        check("R13 dl_slot", dl_slot, 1'b1);
        check("R8 dl_src", dl_src[0], src[0]);
        check("R8 dl_src", dl_src[1], src[1]);
        check("R8 dl_src", dl_src[2], src[2]);
      end else if (m_frm % 4 == 1) begin
        if (crc_byp) e_req = "R4";
        else begin
          logic inv;
          if (k == 0) begin inv = m_pcrc; m_acrc = m_pcrc; m_pcrc = 0; end
          else inv = m_acrc;
          o = m_hold[5-k] ^ inv;
          e_req = "R3/R6";
        end
      end else begin
        o = ((6'b001011 >> (5 - k)) & 6'd1) ^ m_pfs;
        m_pfs = 0;
        e_req = "R2/R7";
      end
    end else if (m_bit == 1 && mimic_en) begin
      o = m_lastf; e_req = "R12";
    end
    if (!(fs && m_frm % 2 == 0 && !fdis)) begin
      #1;
      check("R13/R5 dl_slot", dl_slot, 1'b0);
    end
    if (crc_inv_req) m_pcrc = 1;
    if (fs_inv_req)  m_pfs = 1;
    if (fs) m_lastf = o;
    m_crc = crc_shift(m_crc, fs ? 1'b1 : o);
    e_data = o; e_fpos = fs; e_sfs = fs && (m_frm == 0);
    if (m_bit == 192) begin
      m_bit = 0;
      if (m_frm == 23) begin m_frm = 0; m_hold = m_crc; m_crc = 0; end
      else m_frm++;
    end else m_bit++;
  endtask

  // one bit: compare previous, drive new, model it; entered and left at negedge
  task automatic step(input logic cinv, input logic finv);
    if (have_exp) begin
      check({e_req, " tx_data"}, tx_data, e_data);
      check("R13 tx_fpos", tx_fpos, e_fpos);
      check("R13 tx_sf_start", tx_sf_start, e_sfs);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    din = lfsr[0];
    crc_inv_req = cinv; fs_inv_req = finv;
    if (rnd_src) begin
      boc_valid = lfsr[3] & lfsr[7]; boc_bit = lfsr[4];
      prm_valid = lfsr[5]; prm_bit = lfsr[8];
      hdlc_valid = lfsr[9]; hdlc_bit = lfsr[11];
    end
    model_step();
    have_exp = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  localparam int SF = 193 * 24;

  initial begin
    rst_n = 0; din = 0; j1_mode = 0; fdis = 0; crc_byp = 0; dl_byp = 0; mimic_en = 0;
    crc_inv_req = 0; fs_inv_req = 0; yel_force = 0; auto_yel_en = 0; red_alarm = 0;
    boc_valid = 0; boc_bit = 0; prm_valid = 0; prm_bit = 0; hdlc_valid = 0; hdlc_bit = 0;
    repeat (3) @(negedge clk);
    check("R1 tx_data reset", tx_data, 1'b0);
    check("R1 tx_fpos reset", tx_fpos, 1'b0);
    check("R1 tx_sf_start reset", tx_sf_start, 1'b0);
    model_reset();
    rst_n = 1;
    // R1 R2 R3 R10: T1 idle, two superframes so the CRC of random data is carried
    run_bits(2 * SF);
    // R6 R7: strobes a few bits before the targets in this superframe
    run_bits(100);
    step(1'b1, 1'b1);
    run_bits(SF - 101);
    // R7: second alignment strobe mid-superframe, R6 second pattern unaffected
    run_bits(3 * 193 + 50);
    step(1'b0, 1'b1);
    run_bits(SF - 3 * 193 - 51);
    // R8 R10: random sources, T1 then J1
    rnd_src = 1'b1;
    run_bits(SF);
    j1_mode = 1'b1;
    run_bits(SF);
    // R11: yellow by red alarm with auto enabled, then red alarm alone ignored, then manual
    auto_yel_en = 1'b1; red_alarm = 1'b1;
    run_bits(SF / 2);
    auto_yel_en = 1'b0;
    run_bits(SF / 2);
    j1_mode = 1'b0; yel_force = 1'b1;
    run_bits(SF);
    // R9: data-link bypass with and without yellow
    dl_byp = 1'b1;
    run_bits(SF / 2);
    yel_force = 1'b0; red_alarm = 1'b0;
    run_bits(SF / 2);
    dl_byp = 1'b0;
    // R4: CRC bypass
    crc_byp = 1'b1;
    run_bits(SF);
    crc_byp = 1'b0;
    // R12: mimic
    mimic_en = 1'b1;
    run_bits(SF);
    mimic_en = 1'b0;
    // R5: framing disabled, then back to framing
    fdis = 1'b1;
    run_bits(SF);
    fdis = 1'b0;
    run_bits(2 * SF);
    check("R1 final compare", tx_data, e_data);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule